// File: doc/BRIEF.md
# Two-Way Set-Associative Read Lookup with Interleaved Data Banks

This block is the read side of a small two-way set-associative cache of 1 KB with 4-byte blocks, giving 128 sets per way. A lookup presents a 32-bit physical address and, one cycle later, receives a hit flag and the 16-bit halfword it selects. Each way keeps its own tag array and valid bits. The data of both ways is held in two shared 128-line by 4-byte banks. Each bank line carries one halfword of way 0 and one halfword of way 1, so the final data choice depends on which way hit and on the block-offset bit.

A fill port writes a tag, sets the valid bit and stores a whole 4-byte block into a chosen way and set in a single cycle. It scatters the block's two halfwords across the banks. The port exists so that a bench or an outer controller can load the cache. Lookups use a request channel and a response channel, each with a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the response register is empty or is being drained in that cycle. While the response register is full and `rsp_ready` is low, the response stays frozen and no new request is accepted. The fill port is a plain control port with no handshake. If the tags of both ways matched at once, way 0 would win, but such a state is illegal and is flagged.

Top module: `sa2_lookup`

## Requirements
- R1: Address fields are: tag in bits 31:9, set index in bits 8:2, and halfword select in bit 1 (0 picks the low halfword, bits 15:0 of the block). Bit 0 has no effect on any result.
- R2: A way hits when its valid bit for the indexed set is 1 and its stored tag equals address bits 31:9. `rsp_hit` is the OR of both ways. On a miss, `rsp_data` is 0. The fill user must keep the two tags of a set distinct; a double match is flagged by an assertion.
- R3: On a hit, `rsp_data` is the halfword selected by bit 1 of the block stored in the hitting way. This holds for either way and either halfword.
- R4: When `fill_en` is high at a clock edge, the way `fill_way` (0 or 1) at set `fill_set` takes `fill_tag`, valid = 1 and the block `fill_block` from that edge on. Its low halfword is `fill_block[15:0]`. The other way of that set and all other sets are unchanged.
- R5: A synchronous reset clears every valid bit and empties the response register (`rsp_valid` = 0, `req_ready` = 1).
- R6: A request accepted at a clock edge gives `rsp_valid` = 1 with its result right after that edge.
- R7: While `rsp_valid` = 1 and `rsp_ready` = 0, `req_ready` is 0 and `rsp_hit` and `rsp_data` hold their values. When `rsp_ready` returns to 1, a waiting request is accepted in that same cycle.
- R8: A lookup accepted in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Physical address of the lookup |
| rsp_valid | output | 1 | Response register holds a result |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_hit | output | 1 | Lookup hit in either way |
| rsp_data | output | 16 | Selected halfword, 0 on a miss |
| fill_en | input | 1 | Write a block this cycle |
| fill_way | input | 1 | Way to write |
| fill_set | input | 7 | Set to write |
| fill_tag | input | 23 | Tag stored with the block |
| fill_block | input | 32 | Block contents, low halfword in bits 15:0 |

## Verification
Several properties are checked on every cycle. A fill sets its valid bit on the next edge. Reset leaves all valid bits clear. An accepted request yields a response on the next edge. A stalled response stays stable. A miss returns zero data. No accepted lookup sees both ways match. The scenarios alone show that the halfword lanes and banks are swizzled correctly, because the bench computes expected data from a plain per-way model of the blocks. They also show that address bit 0 is ignored, that a fill leaves the other way intact, and that a lookup in the same cycle as a fill returns the old contents.

// File: rtl/sa2_pkg.sv
package sa2_pkg;
  localparam int unsigned ADDR_W_D = 32;
  localparam int unsigned SET_W_D  = 7;
  localparam int unsigned HALF_W_D = 16;

  // Bank that holds halfword 'half' of a block living in way 'way'.
  function automatic logic bank_of(input logic way, input logic half);
    return way ^ half;
  endfunction
endpackage

// File: rtl/sa2_tag_way.sv
module sa2_tag_way #(
  parameter int unsigned SET_W = 7,
  parameter int unsigned TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set] <= wr_tag;
  end

  assign hit = valid_q[rd_set] && (tag_mem[rd_set] == rd_tag);

  p_fill_valid_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_set)]);

  p_reset_clear_r5: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0));
endmodule

// File: rtl/sa2_data_bank.sv
module sa2_data_bank #(
  parameter int unsigned SET_W  = 7,
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              rd_lane,
  output logic [HALF_W-1:0] rd_half,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_lane,
  input  logic [HALF_W-1:0] wr_half
);
  localparam int unsigned SETS   = 1 << SET_W;
  localparam int unsigned LINE_W = 2 * HALF_W;

  logic [LINE_W-1:0] line_mem [SETS];
  logic [LINE_W-1:0] line;

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_set][wr_lane*HALF_W +: HALF_W] <= wr_half;
  end

  assign line    = line_mem[rd_set];
  assign rd_half = rd_lane ? line[LINE_W-1:HALF_W] : line[HALF_W-1:0];
endmodule

// File: rtl/sa2_lookup.sv
module sa2_lookup #(
  parameter int unsigned ADDR_W = sa2_pkg::ADDR_W_D,
  parameter int unsigned SET_W  = sa2_pkg::SET_W_D,
  parameter int unsigned HALF_W = sa2_pkg::HALF_W_D,
  localparam int unsigned TAG_W = ADDR_W - SET_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [HALF_W-1:0] rsp_data,
  input  logic              fill_en,
  input  logic              fill_way,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [2*HALF_W-1:0] fill_block
);
  localparam int unsigned WAYS = 2;

  logic [TAG_W-1:0]  a_tag;
  logic [SET_W-1:0]  a_set;
  logic              a_half;
  logic              unused_byte_bit;
  logic [WAYS-1:0]   way_hit;
  logic              any_hit;
  logic              sel_way;
  logic              pick_bank;
  logic [HALF_W-1:0] bank_half [WAYS];
  logic [HALF_W-1:0] look_data;
  logic              req_fire;

  assign a_tag           = req_addr[ADDR_W-1 -: TAG_W];
  assign a_set           = req_addr[SET_W+1:2];
  assign a_half          = req_addr[1];
  assign unused_byte_bit = req_addr[0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sa2_tag_way #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .rst    (rst),
      .rd_set (a_set),
      .rd_tag (a_tag),
      .hit    (way_hit[w]),
      .wr_en  (fill_en && (fill_way == w[0])),
      .wr_set (fill_set),
      .wr_tag (fill_tag)
    );
  end

  assign any_hit   = |way_hit;
  assign sel_way   = !way_hit[0];
  assign pick_bank = sa2_pkg::bank_of(sel_way, a_half);

  for (genvar k = 0; k < WAYS; k++) begin : g_bank
    // Bank k holds halfword (k ^ way) of each way, in lane 'way'.
    logic wr_hsel;
    assign wr_hsel = k[0] ^ fill_way;
    sa2_data_bank #(.SET_W(SET_W), .HALF_W(HALF_W)) u_bank (
      .clk     (clk),
      .rd_set  (a_set),
      .rd_lane (sel_way),
      .rd_half (bank_half[k]),
      .wr_en   (fill_en),
      .wr_set  (fill_set),
      .wr_lane (fill_way),
      .wr_half (wr_hsel ? fill_block[2*HALF_W-1:HALF_W] : fill_block[HALF_W-1:0])
    );
  end

  assign look_data = any_hit ? bank_half[pick_bank] : '0;
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit;
      rsp_data  <= look_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_two_way_hit_r2: assert property (@(posedge clk) disable iff (rst)
    req_fire |-> !(way_hit[0] && way_hit[1]));

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> rsp_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_data)));
endmodule

// File: tb/sa2_lookup_tb.sv
module sa2_lookup_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_hit;
  logic [15:0] rsp_data;
  logic        fill_en;
  logic        fill_way;
  logic [6:0]  fill_set;
  logic [22:0] fill_tag;
  logic [31:0] fill_block;

  int total = 0;
  int bad   = 0;

  logic [22:0] m_tag [2][128];
  logic        m_val [2][128];
  logic [31:0] m_blk [2][128];

  always #2 clk = ~clk;

  sa2_lookup u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .fill_en(fill_en),
    .fill_way(fill_way), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_block(fill_block)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] model(input logic [31:0] a);
    logic [16:0] r;
    r = '0;
    for (int w = 1; w >= 0; w--) begin
      if (m_val[w][a[8:2]] && m_tag[w][a[8:2]] == a[31:9])
        r = {1'b1, a[1] ? m_blk[w][a[8:2]][31:16] : m_blk[w][a[8:2]][15:0]};
    end
    return r;
  endfunction

  function automatic logic [22:0] legal_tag(input logic w, input logic [6:0] s, input logic [22:0] t);
    if (m_val[!w][s] && m_tag[!w][s] == t) return t ^ 23'h1;
    return t;
  endfunction

  task automatic model_fill(input logic w, input logic [6:0] s, input logic [22:0] t, input logic [31:0] b);
    m_tag[w][s] = t; m_val[w][s] = 1'b1; m_blk[w][s] = b;
  endtask

  task automatic do_fill(input logic w, input logic [6:0] s, input logic [22:0] t, input logic [31:0] b);
    @(negedge clk);
    fill_en = 1'b1; fill_way = w; fill_set = s; fill_tag = t; fill_block = b;
    @(negedge clk);
    fill_en = 1'b0;
    model_fill(w, s, t, b);
  endtask

  task automatic do_look(input string req, input logic [31:0] a);
    logic [16:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    e = model(a);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " hit"},   {31'd0, rsp_hit},   {31'd0, e[16]});
    check({req, " data"},  {16'd0, rsp_data},  {16'd0, e[15:0]});
  endtask

  function automatic logic [31:0] mk_addr(input logic [22:0] t, input logic [6:0] s, input logic h, input logic b0);
    return {t, s, h, b0};
  endfunction

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [16:0] e;
    void'($urandom(32'h5A2D1));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 128; s++) begin m_val[w][s] = 1'b0; m_tag[w][s] = '0; m_blk[w][s] = '0; end
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    fill_en = 1'b0; fill_way = 1'b0; fill_set = '0; fill_tag = '0; fill_block = '0;
    repeat (3) @(negedge clk);
    check("R5 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R5 reset req_ready", {31'd0, req_ready}, 32'd1);
    rst = 1'b0;

    do_look("R2 empty miss", 32'h0000_0000);

    // Both ways of one set, distinct blocks, every halfword (R3, R1)
    do_fill(1'b0, 7'd5, 23'h1234, 32'hAAAA_1111);
    do_fill(1'b1, 7'd5, 23'h0777, 32'hBBBB_2222);
    do_look("R3 w0 h0", mk_addr(23'h1234, 7'd5, 1'b0, 1'b0));
    do_look("R3 w0 h1", mk_addr(23'h1234, 7'd5, 1'b1, 1'b0));
    do_look("R3 w1 h0", mk_addr(23'h0777, 7'd5, 1'b0, 1'b0));
    do_look("R3 w1 h1", mk_addr(23'h0777, 7'd5, 1'b1, 1'b0));
    do_look("R1 bit0 ignored", mk_addr(23'h0777, 7'd5, 1'b1, 1'b1));
    do_look("R2 tag msb differs", mk_addr(23'h1234 ^ 23'h400000, 7'd5, 1'b0, 1'b0));
    do_look("R1 other set misses", mk_addr(23'h1234, 7'd6, 1'b0, 1'b0));

    // Edge sets and overwrite leaving the other way intact (R4)
    do_fill(1'b1, 7'd0,   23'h7FFFFF, 32'hCAFE_BEEF);
    do_fill(1'b0, 7'd127, 23'h000001, 32'h0102_0304);
    do_look("R4 set0 w1", mk_addr(23'h7FFFFF, 7'd0, 1'b1, 1'b0));
    do_look("R4 set127 w0", mk_addr(23'h000001, 7'd127, 1'b0, 1'b0));
    do_fill(1'b0, 7'd5, 23'h1235, 32'h5555_6666);
    do_look("R4 old tag gone", mk_addr(23'h1234, 7'd5, 1'b0, 1'b0));
    do_look("R4 new tag", mk_addr(23'h1235, 7'd5, 1'b1, 1'b0));
    do_look("R4 other way kept", mk_addr(23'h0777, 7'd5, 1'b0, 1'b0));

    // Lookup in the same cycle as a fill of the same line (R8)
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk_addr(23'h0888, 7'd9, 1'b0, 1'b0);
    fill_en = 1'b1; fill_way = 1'b1; fill_set = 7'd9; fill_tag = 23'h0888; fill_block = 32'h9999_8888;
    e = model(req_addr);
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    model_fill(1'b1, 7'd9, 23'h0888, 32'h9999_8888);
    check("R8 same-cycle sees old", {31'd0, rsp_hit}, {31'd0, e[16]});
    do_look("R8 next lookup sees new", mk_addr(23'h0888, 7'd9, 1'b0, 1'b0));

    // Back-pressure (R7, R6)
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = mk_addr(23'h0777, 7'd5, 1'b1, 1'b0);
    e = model(req_addr);
    @(negedge clk);
    check("R6 valid after one edge", {31'd0, rsp_valid}, 32'd1);
    req_addr = mk_addr(23'h1235, 7'd5, 1'b0, 1'b0);
    repeat (2) begin
      check("R7 req_ready low", {31'd0, req_ready}, 32'd0);
      check("R7 data held", {16'd0, rsp_data}, {16'd0, e[15:0]});
      @(negedge clk);
    end
    e = model(req_addr);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 waiting request taken", {15'd0, rsp_hit, rsp_data}, {15'd0, e});
    @(negedge clk);
    check("R7 drained", {31'd0, rsp_valid}, 32'd0);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic w; logic [6:0] s; logic [22:0] t;
        w = 1'($urandom_range(0, 1));
        s = 7'($urandom_range(0, 127));
        t = legal_tag(w, s, 23'($urandom_range(0, 15)));
        do_fill(w, s, t, $urandom);
      end else begin
        logic [6:0] s; logic [22:0] t;
        s = 7'($urandom_range(0, 127));
        t = 23'($urandom_range(0, 15));
        do_look("R3 random", mk_addr(t, s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
      end
    end

    // Reset clears all valid bits (R5)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int w = 0; w < 2; w++) for (int s = 0; s < 128; s++) m_val[w][s] = 1'b0;
    do_look("R5 miss after reset", mk_addr(23'h0777, 7'd5, 1'b0, 1'b0));
    do_look("R5 miss after reset 2", mk_addr(23'h7FFFFF, 7'd0, 1'b1, 1'b0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule